// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Sequencer

This block runs the full programming flow for a byte-wide one-time-programmable memory over a fixed address range. A single start strobe begins the flow. The block asks for the raised core supply, then the raised programming voltage. Pass 1 writes every byte with one timed pulse on the active-low chip enable. Pass 2 walks the range again and reads each byte back through the active-low output enable. A byte that reads wrong gets one more pulse, then another read, up to a fixed retry limit. The supplies are then lowered in the reverse order, and a final pass re-reads every byte at normal supply and compares it with the expected data.

The host supplies the expected byte for the address currently shown on `mem_addr_o`, with no handshake. All setup, hold, pulse and access times are parameters counted in clock cycles, so one timer serves every phase. The supplies themselves are out of scope: the block only raises or drops two request levels. The result is a pass flag and the first failing address, both held until the next start. The retry count and the current address are visible at all times.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, chip enable and output enable are high (inactive), the data bus enable and both supply requests are low, and `busy_o`, `done_o` and `pass_o` are 0.
- R2: The core request `vcc_prog_req_o` rises exactly T_RAIL cycles before the programming request `vpp_prog_req_o`. It falls exactly T_RAIL cycles after that request falls. The programming request is never high while the core request is low. The programming request is high for exactly T_VPP + T_SETUP cycles before the first chip-enable pulse.
- R3: Each program pulse holds `mem_ce_n_o` low for exactly T_PULSE cycles. During the pulse, output enable is high, the data bus is driven, and the address stays constant.
- R4: Before each pulse, the data bus is driven with output enable high for at least T_SETUP cycles, and the first pulse of a run has exactly T_SETUP cycles of setup. After each pulse, the data and address are held for at least T_HOLD cycles.
- R5: Pass 1 applies exactly one pulse to each address in ascending order, starting at 0, with no read in between. The first output-enable fall comes only after all of these pulses.
- R6: Each read holds `mem_oe_n_o` low for exactly T_OE cycles and samples the data on the last of them. The data bus is never driven while output enable is low. After output enable rises, the bus stays undriven for at least T_FLOAT cycles.
- R7: In pass 2, a byte that reads back wrong gets another pulse and another read, at most MAX_RETRY times. `retry_cnt_o` shows how many retry pulses the current byte has had, and it returns to 0 at the next address. A byte that needs exactly MAX_RETRY retries still passes.
- R8: If a byte still reads wrong after MAX_RETRY retries, no further pulses are applied and no final compare is run. Both supplies are lowered in order, the run ends with `pass_o` = 0, and `fail_addr_o` holds that address.
- R9: The final pass reads every address with both supply requests low. The run passes only if every byte matches. Otherwise `fail_addr_o` holds the first (lowest) mismatching address, and the pass still reads the whole range.
- R10: `done_o` is high for exactly one cycle at the end of a run, and `busy_o` is low after it. A start strobe during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (ignored while busy) |
| host_data_i | input | DATA_W | Expected byte for the address on `mem_addr_o` |
| mem_addr_o | output | ADDR_W | Memory address, also the current address |
| mem_wdata_o | output | DATA_W | Data driven to the memory |
| mem_wdata_oe_o | output | 1 | Drive enable for the data bus |
| mem_rdata_i | input | DATA_W | Data read from the memory |
| mem_ce_n_o | output | 1 | Chip enable, low during a program pulse |
| mem_oe_n_o | output | 1 | Output enable, low during a read |
| vcc_prog_req_o | output | 1 | Request raised core supply |
| vpp_prog_req_o | output | 1 | Request programming voltage |
| retry_cnt_o | output | RETRY_W | Retry pulses applied to the current byte |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| pass_o | output | 1 | Last run passed |
| fail_addr_o | output | ADDR_W | First failing address of the last run |

## Verification
Most internal errors show up at the pins within one phase. If the phase timer is off, a pulse, setup, read or float window has the wrong width at the very first program step. If the address counter is wrong, the pass-1 pulse order breaks, or the first output-enable fall comes before the full range has been pulsed. A wrong retry or mismatch decision only shows up when a byte needs several pulses. It then appears as a wrong per-address pulse total, as a retry count above the limit, or as a false pass or fail at `done_o`. A fault in the fail-capture register only appears at the end of a run, where the reported address is not the first bad one.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VCC_UP,
    ST_VPP_UP,
    ST_PG_SETUP,
    ST_PG_PULSE,
    ST_PG_HOLD,
    ST_VF_READ,
    ST_VF_FLOAT,
    ST_VPP_DN,
    ST_VCC_DN,
    ST_FC_READ,
    ST_FC_FLOAT,
    ST_DONE
  } seq_state_e;

  typedef enum logic {
    PH_FIRST,
    PH_VERIFY
  } seq_phase_e;

  function automatic logic is_read_state(input seq_state_e s);
    return (s == ST_VF_READ) || (s == ST_FC_READ);
  endfunction

  function automatic logic is_drive_state(input seq_state_e s);
    return (s == ST_PG_SETUP) || (s == ST_PG_PULSE) || (s == ST_PG_HOLD);
  endfunction

  function automatic logic is_vpp_state(input seq_state_e s);
    return (s == ST_VPP_UP) || is_drive_state(s) ||
           (s == ST_VF_READ) || (s == ST_VF_FLOAT);
  endfunction

  function automatic logic is_vcc_state(input seq_state_e s);
    return is_vpp_state(s) || (s == ST_VCC_UP) || (s == ST_VPP_DN);
  endfunction

endpackage

// File: rtl/otp_step_timer.sv
module otp_step_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end

  assert_timer_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/otp_fail_capture.sv
module otp_fail_capture #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              fail_ev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              finish_i,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              failed_o,
  output logic              pass_o
);
  logic finished_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_addr_o <= '0;
      failed_o    <= 1'b0;
      finished_q  <= 1'b0;
    end else if (clear_i) begin
      fail_addr_o <= '0;
      failed_o    <= 1'b0;
      finished_q  <= 1'b0;
    end else begin
      if (fail_ev_i && !failed_o) begin
        fail_addr_o <= addr_i;
        failed_o    <= 1'b1;
      end
      if (finish_i) finished_q <= 1'b1;
    end
  end

  assign pass_o = finished_q && !failed_o;

  assert_first_fail_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (failed_o && !clear_i) |=> $stable(fail_addr_o));

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int T_RAIL    = 250,
  parameter int T_VPP     = 250,
  parameter int T_SETUP   = 250,
  parameter int T_PULSE   = 12500,
  parameter int T_HOLD    = 250,
  parameter int T_OE      = 19,
  parameter int T_FLOAT   = 17,
  parameter int MAX_RETRY = 10,
  parameter int RETRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [DATA_W-1:0]  host_data_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               mem_wdata_oe_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               mem_ce_n_o,
  output logic               mem_oe_n_o,
  output logic               vcc_prog_req_o,
  output logic               vpp_prog_req_o,
  output logic [RETRY_W-1:0] retry_cnt_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               pass_o,
  output logic [ADDR_W-1:0]  fail_addr_o
);

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_MAX = max_of(max_of(max_of(T_RAIL, T_VPP), max_of(T_SETUP, T_PULSE)),
                                max_of(max_of(T_HOLD, T_OE), T_FLOAT));
  localparam int CNT_W = $clog2(T_MAX + 1) + 1;
  localparam logic [ADDR_W-1:0]  LAST_ADDR = '1;
  localparam logic [RETRY_W-1:0] RETRY_LIM = RETRY_W'(MAX_RETRY);

  function automatic logic [CNT_W-1:0] dwell(input seq_state_e s);
    case (s)
      ST_VCC_UP, ST_VPP_DN, ST_VCC_DN: return CNT_W'(T_RAIL);
      ST_VPP_UP:                       return CNT_W'(T_VPP);
      ST_PG_SETUP:                     return CNT_W'(T_SETUP);
      ST_PG_PULSE:                     return CNT_W'(T_PULSE);
      ST_PG_HOLD:                      return CNT_W'(T_HOLD);
      ST_VF_READ, ST_FC_READ:          return CNT_W'(T_OE);
      ST_VF_FLOAT, ST_FC_FLOAT:        return CNT_W'(T_FLOAT);
      default:                         return CNT_W'(1);
    endcase
  endfunction

  function automatic logic bytes_equal(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  seq_state_e         state_q, state_d;
  seq_phase_e         phase_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [RETRY_W-1:0] retry_q;
  logic               match_q;
  logic               abort_q;
  logic [CNT_W-1:0]   tcnt;

  // named internal events
  logic ev_tmo, ev_start, ev_sample, ev_last, ev_give_up, ev_cmp_bad, ev_finish;
  logic fail_ev, failed;

  assign ev_tmo     = (tcnt == dwell(state_q) - 1'b1);
  assign ev_start   = (state_q == ST_IDLE) && start_i;
  assign ev_sample  = is_read_state(state_q) && ev_tmo;
  assign ev_last    = (addr_q == LAST_ADDR);
  assign ev_give_up = (state_q == ST_VF_FLOAT) && ev_tmo && !match_q && (retry_q == RETRY_LIM);
  assign ev_cmp_bad = (state_q == ST_FC_FLOAT) && ev_tmo && !match_q;
  assign ev_finish  = (state_d == ST_DONE) && (state_q != ST_DONE);
  assign fail_ev    = ev_give_up || ev_cmp_bad;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_VCC_UP;
      ST_VCC_UP:   if (ev_tmo) state_d = ST_VPP_UP;
      ST_VPP_UP:   if (ev_tmo) state_d = ST_PG_SETUP;
      ST_PG_SETUP: if (ev_tmo) state_d = ST_PG_PULSE;
      ST_PG_PULSE: if (ev_tmo) state_d = ST_PG_HOLD;
      ST_PG_HOLD:
        if (ev_tmo) state_d = (phase_q == PH_FIRST && !ev_last) ? ST_PG_SETUP : ST_VF_READ;
      ST_VF_READ:  if (ev_tmo) state_d = ST_VF_FLOAT;
      ST_VF_FLOAT:
        if (ev_tmo) begin
          if (match_q)         state_d = ev_last ? ST_VPP_DN : ST_VF_READ;
          else if (ev_give_up) state_d = ST_VPP_DN;
          else                 state_d = ST_PG_SETUP;
        end
      ST_VPP_DN:   if (ev_tmo) state_d = ST_VCC_DN;
      ST_VCC_DN:   if (ev_tmo) state_d = abort_q ? ST_DONE : ST_FC_READ;
      ST_FC_READ:  if (ev_tmo) state_d = ST_FC_FLOAT;
      ST_FC_FLOAT: if (ev_tmo) state_d = ev_last ? ST_DONE : ST_FC_READ;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_FIRST;
      addr_q  <= '0;
      retry_q <= '0;
      match_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_sample) match_q <= bytes_equal(mem_rdata_i, host_data_i);
      case (state_q)
        ST_IDLE:
          if (start_i) begin
            phase_q <= PH_FIRST;
            addr_q  <= '0;
            retry_q <= '0;
            abort_q <= 1'b0;
          end
        ST_PG_HOLD:
          if (ev_tmo && phase_q == PH_FIRST) begin
            if (ev_last) begin
              phase_q <= PH_VERIFY;
              addr_q  <= '0;
            end else begin
              addr_q  <= addr_q + 1'b1;
            end
          end
        ST_VF_FLOAT:
          if (ev_tmo) begin
            if (match_q) begin
              retry_q <= '0;
              if (!ev_last) addr_q <= addr_q + 1'b1;
            end else if (ev_give_up) begin
              abort_q <= 1'b1;
            end else begin
              retry_q <= retry_q + 1'b1;
            end
          end
        ST_VCC_DN:
          if (ev_tmo) begin
            addr_q  <= '0;
            retry_q <= '0;
          end
        ST_FC_FLOAT:
          if (ev_tmo && !ev_last) addr_q <= addr_q + 1'b1;
        default: ;
      endcase
    end
  end

  otp_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state_d != state_q),
    .cnt_o (tcnt)
  );

  otp_fail_capture #(.ADDR_W(ADDR_W)) u_fail (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (ev_start),
    .fail_ev_i   (fail_ev),
    .addr_i      (addr_q),
    .finish_i    (ev_finish),
    .fail_addr_o (fail_addr_o),
    .failed_o    (failed),
    .pass_o      (pass_o)
  );

  assign mem_addr_o     = addr_q;
  assign mem_wdata_o    = host_data_i;
  assign mem_wdata_oe_o = is_drive_state(state_q);
  assign mem_ce_n_o     = (state_q != ST_PG_PULSE);
  assign mem_oe_n_o     = !is_read_state(state_q);
  assign vpp_prog_req_o = is_vpp_state(state_q);
  assign vcc_prog_req_o = is_vcc_state(state_q);
  assign retry_cnt_o    = retry_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = (state_q == ST_DONE);

  // pulse-width window kept with a counter
  logic [CNT_W-1:0] pw_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pw_cnt <= '0;
    else if (!mem_ce_n_o) pw_cnt <= pw_cnt + 1'b1;
    else                  pw_cnt <= '0;
  end

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce_n_o)) |-> (pw_cnt == CNT_W'(T_PULSE)));
  assert_pulse_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o) |-> (mem_oe_n_o && mem_wdata_oe_o && vpp_prog_req_o));
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o && !$fell(mem_ce_n_o)) |-> $stable(mem_addr_o));
  assert_vpp_needs_vcc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_prog_req_o |-> vcc_prog_req_o);
  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n_o) |-> !mem_wdata_oe_o);
  assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt_o <= RETRY_LIM);
  assert_give_up_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_give_up |=> (!vpp_prog_req_o && mem_ce_n_o));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  assert_fail_reported_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && failed) |-> !pass_o);

endmodule

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;
  localparam int AW = 3, DW = 8, NB = 1 << AW;
  localparam int TR = 3, TV = 4, TS = 3, TP = 8, TH = 2, TO = 2, TF = 2, MR = 10;
  localparam int RW = $clog2(MR + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr, fail_addr;
  logic [DW-1:0] wdata, rdata, host;
  logic wdoe, ce_n, oe_n, vcc, vpp, busy, done, pass;
  logic [RW-1:0] retry;

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [7:0] seed = 8'h11;
  logic [DW-1:0] mem [NB];
  int need [NB];
  int pulses [NB];
  bit corrupt [NB];

  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a, input logic [7:0] s);
    return DW'((int'(a) * 37 + int'(s)) & 8'h7F);
  endfunction

  assign host  = pattern(addr, seed);
  assign rdata = mem[addr] ^ ((!vcc && corrupt[addr]) ? 8'h01 : 8'h00);

  otp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .T_RAIL(TR), .T_VPP(TV), .T_SETUP(TS),
    .T_PULSE(TP), .T_HOLD(TH), .T_OE(TO), .T_FLOAT(TF), .MAX_RETRY(MR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .host_data_i(host),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_wdata_oe_o(wdoe), .mem_rdata_i(rdata),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .vcc_prog_req_o(vcc), .vpp_prog_req_o(vpp),
    .retry_cnt_o(retry), .busy_o(busy), .done_o(done), .pass_o(pass), .fail_addr_o(fail_addr));

  // port monitor
  logic p_ce = 1, p_oe = 1, p_vpp = 0, p_vcc = 0, p_wdoe = 0;
  int vcc_only, vcc_lead, vcc_trail, vpp_on, first_lead, ce_low, su, first_su;
  int hold_c, oe_low, float_c, total, at_first_oe, fc_reads, max_retry;
  int bad_sup, bad_pw, bad_order, bad_su, bad_hold, bad_oe, bad_float, bad_bus;
  bit hold_run, float_run, seen_ce, seen_oe;
  logic [AW-1:0] hold_addr;

  task automatic clear_mon();
    vcc_only = 0; vcc_lead = -1; vcc_trail = -1; vpp_on = 0; first_lead = -1; ce_low = 0;
    su = 0; first_su = -1; hold_c = 0; oe_low = 0; float_c = 0; total = 0; at_first_oe = -1;
    fc_reads = 0; max_retry = 0; bad_sup = 0; bad_pw = 0; bad_order = 0; bad_su = 0;
    bad_hold = 0; bad_oe = 0; bad_float = 0; bad_bus = 0; hold_run = 0; float_run = 0;
    seen_ce = 0; seen_oe = 0;
    for (int i = 0; i < NB; i++) begin
      mem[i] = 8'hFF; need[i] = 1; pulses[i] = 0; corrupt[i] = 0;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (vpp && !vcc) bad_sup++;
    if (vpp && !p_vpp) vcc_lead = vcc_only;
    if (!vcc && p_vcc) vcc_trail = vcc_only;
    vcc_only = (vcc && !vpp) ? vcc_only + 1 : 0;
    if (!ce && p_ce) begin
      if (!seen_ce) begin first_lead = vpp_on; first_su = su; seen_ce = 1; end
      if (su < TS) bad_su++;
      if (oe_n == 0 || !wdoe) bad_bus++;
    end
    if (vpp) vpp_on++;
    if (!ce_n) ce_low++;
    if (ce_n && !p_ce) begin
      if (ce_low != TP) bad_pw++;
      ce_low = 0; su = 0;
      if (total < NB && int'(addr) != total) bad_order++;
      total++; pulses[addr]++;
      if (pulses[addr] >= need[addr]) mem[addr] = wdata;
      hold_run = 1; hold_c = 0; hold_addr = addr;
    end
    if (hold_run) begin
      if (!wdoe || addr != hold_addr) begin
        if (hold_c < TH) bad_hold++;
        hold_run = 0;
      end else hold_c++;
    end
    if (wdoe && ce_n && oe_n) su++;
    if (!oe_n && p_oe) begin
      if (!seen_oe) begin at_first_oe = total; seen_oe = 1; end
      if (!vcc) fc_reads++;
    end
    if (!oe_n) begin oe_low++; if (wdoe) bad_bus++; end
    if (oe_n && !p_oe) begin
      if (oe_low != TO) bad_oe++;
      oe_low = 0; float_run = 1; float_c = 0;
    end
    if (float_run) begin
      if (wdoe) begin if (float_c < TF) bad_float++; float_run = 0; end
      else if (oe_n) float_c++;
      if (!oe_n) float_run = 0;
    end
    if (int'(retry) > max_retry) max_retry = int'(retry);
    p_ce = ce_n; p_oe = oe_n; p_vpp = vpp; p_vcc = vcc; p_wdoe = wdoe;
  end

  wire ce = ce_n;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  bit got_pass;
  logic [AW-1:0] got_faddr;

  task automatic run_flow();
    int guard = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R10 run reached done", int'(done), 1);
    got_pass = pass; got_faddr = fail_addr;
    @(negedge clk);
    chk(!done && !busy, "R10 done single cycle then idle", int'({done, busy}), 0);
  endtask

  task automatic check_timing(input string tag);
    chk(bad_sup == 0, "R2 vpp without vcc", bad_sup, 0);
    chk(vcc_lead == TR, "R2 vcc lead", vcc_lead, TR);
    chk(vcc_trail == TR, "R2 vcc trail", vcc_trail, TR);
    chk(first_lead == TV + TS, "R2 vpp before first pulse", first_lead, TV + TS);
    chk(bad_pw == 0, "R3 pulse width", bad_pw, 0);
    chk(first_su == TS && bad_su == 0, "R4 setup", first_su, TS);
    chk(bad_hold == 0, "R4 hold", bad_hold, 0);
    chk(bad_order == 0, "R5 pass-1 order", bad_order, 0);
    chk(at_first_oe == NB, "R5 no read in pass 1", at_first_oe, NB);
    chk(bad_oe == 0 && bad_bus == 0, "R6 read window and bus", bad_oe + bad_bus, 0);
    chk(bad_float == 0, "R6 float gap", bad_float, 0);
    $display("[TB] timing checks done: %s", tag);
  endtask

  task automatic test_reset();
    chk(ce_n && oe_n && !wdoe, "R1 reset memory controls", int'({ce_n, oe_n, wdoe}), 6);
    chk(!vcc && !vpp, "R1 reset supply requests", int'({vcc, vpp}), 0);
    chk(!busy && !done && !pass, "R1 reset status", int'({busy, done, pass}), 0);
  endtask

  task automatic test_clean();
    clear_mon(); seed = 8'h11;
    run_flow();
    check_timing("clean");
    chk(got_pass, "R9 clean run passes", int'(got_pass), 1);
    chk(total == 2 * 0 + NB, "R7 no retries when all verify", total, NB);
    chk(max_retry == 0, "R7 retry count stays 0", max_retry, 0);
    chk(fc_reads == NB, "R9 final reads at normal supply", fc_reads, NB);
  endtask

  task automatic test_retries();
    clear_mon(); seed = 8'h23;
    need[2] = 3; need[5] = MR + 1;
    run_flow();
    check_timing("retries");
    chk(got_pass, "R7 run with retries passes", int'(got_pass), 1);
    chk(pulses[2] == 3, "R7 pulses on slow byte", pulses[2], 3);
    chk(pulses[5] == MR + 1, "R7 limit-exact byte", pulses[5], MR + 1);
    chk(pulses[6] == 1, "R7 retry count reset at next address", pulses[6], 1);
    chk(max_retry == MR, "R7 retry count peak", max_retry, MR);
  endtask

  task automatic test_exhaust();
    clear_mon(); seed = 8'h35;
    need[4] = MR + 2;
    run_flow();
    chk(!got_pass, "R8 exhausted byte fails run", int'(got_pass), 0);
    chk(got_faddr == 3'd4, "R8 fail address", int'(got_faddr), 4);
    chk(pulses[4] == MR + 1, "R8 pulses stop at limit", pulses[4], MR + 1);
    chk(pulses[5] == 1, "R8 later bytes untouched in pass 2", pulses[5], 1);
    chk(fc_reads == 0, "R8 no final compare", fc_reads, 0);
    chk(vcc_trail == TR && bad_sup == 0, "R8 supplies lowered in order", vcc_trail, TR);
  endtask

  task automatic test_final_cmp();
    clear_mon(); seed = 8'h47;
    corrupt[3] = 1; corrupt[6] = 1;
    run_flow();
    chk(!got_pass, "R9 final mismatch fails run", int'(got_pass), 0);
    chk(got_faddr == 3'd3, "R9 first mismatching address", int'(got_faddr), 3);
    chk(fc_reads == NB, "R9 whole range compared", fc_reads, NB);
  endtask

  task automatic test_busy_start();
    int guard = 0;
    clear_mon(); seed = 8'h59;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    got_pass = pass;
    repeat (20) @(negedge clk);
    chk(!busy, "R10 start while busy ignored", int'(busy), 0);
    chk(total == NB, "R10 no extra pulses", total, NB);
    chk(got_pass, "R10 interrupted-start run passes", int'(got_pass), 1);
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_clean();
    test_retries();
    test_exhaust();
    test_final_cmp();
    test_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule